// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading two entries from memory in sequence. The first read fetches an entry from a page directory whose base comes from a directory base input. The second read fetches an entry from the page table that the first entry points to. Each fetched entry keeps its upper 20 bits as a 4 KiB-aligned base. Its lower 12 bits are flags, and of these only the present flag in bit 0 is interpreted.

A client offers a request while `req_ready_o` is high. The walker then issues its memory reads one at a time over a simple request/acknowledge port, and reports the outcome with a single-cycle `done_valid_o` pulse. The outcome is either a physical address, or a not-present fault together with the level that caused it. Changing the directory base selects a different mapping for every request accepted after the change.

Top module: `pgwalk`

## Requirements
- R1: After a synchronous reset, `req_ready_o` is 1 and both `mem_rd_req_o` and `done_valid_o` are 0.
- R2: The first memory read of a walk goes to the directory base with its low 12 bits cleared, plus 4 times the linear address bits [31:22]. The low 12 bits of `dir_base_i` have no effect on this address.
- R3: The second memory read goes to the directory entry with its low 12 bits cleared, plus 4 times the linear address bits [21:12]. The flag bits [11:1] of the directory entry have no effect on this address.
- R4: When both entries have bit 0 set, the walk reports `done_fault_o`=0 and `done_paddr_o` equal to the table entry with bits [11:0] replaced by the linear address bits [11:0].
- R5: A directory entry with bit 0 clear ends the walk after exactly one memory read. It reports `done_fault_o`=1, `done_lvl_o`=0 and `done_paddr_o`=0.
- R6: A table entry with bit 0 clear ends the walk after exactly two memory reads. It reports `done_fault_o`=1, `done_lvl_o`=1 and `done_paddr_o`=0.
- R7: While `mem_rd_req_o` is high and `mem_rd_ack_i` is low, the request stays high and `mem_rd_addr_o` stays unchanged in the next cycle.
- R8: A request is taken only on a clock edge where both `req_valid_i` and `req_ready_o` are high. `req_ready_o` stays low from that edge until the cycle after the result pulse, and it is never high while a memory read is pending.
- R9: The directory base is sampled when the request is taken. Changing `dir_base_i` during a walk does not alter that walk, and the next request uses the new base.
- R10: `done_valid_o` is high for exactly one cycle per walk. The following cycle has `req_ready_o` high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_base_i | input | 32 | Page directory base (low 12 bits ignored) |
| req_valid_i | input | 1 | Translation request offered |
| req_ready_o | output | 1 | Walker idle and able to take a request |
| req_addr_i | input | 32 | Linear address to translate |
| mem_rd_req_o | output | 1 | Memory read request, held until acknowledged |
| mem_rd_addr_o | output | 32 | Byte address of the entry being read |
| mem_rd_ack_i | input | 1 | Memory acknowledge; data valid in the same cycle |
| mem_rd_data_i | input | 32 | Entry word returned by memory |
| done_valid_o | output | 1 | One-cycle pulse when a walk ends |
| done_fault_o | output | 1 | Walk ended on a not-present entry |
| done_lvl_o | output | 1 | Faulting level: 0 directory, 1 table |
| done_paddr_o | output | 32 | Physical address (0 on a fault) |

## Verification
The bench targets three kinds of mistake. The first is flag bits leaking into addresses: random nonzero flags in every entry and in the low bits of the base would show up as wrong read addresses or a wrong physical address if the masking were missing. The second is a fault taken at the wrong level. The bench forces a missing directory entry and, separately, a missing table entry, and it counts the memory reads, so a walker that reads a table after a directory fault, or that reports the wrong level, is caught. The third is a walker that reads the live base instead of the base captured at acceptance. The bench swaps `dir_base_i` in the middle of a walk to expose it. Random acknowledge latency checks that reads are held steady and that no request is taken while the walker is busy.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DIR   = 3'd1,
    ST_TBL   = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } walk_state_t;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_TBL = 1'b1
  } walk_level_t;
endpackage

// File: rtl/pgwalk_addr.sv
// Address arithmetic: entry addresses and final physical address.
module pgwalk_addr #(
  parameter int AW          = 32,
  parameter int OFF_W       = 12,
  parameter int IDX_W       = 10,
  parameter int ENT_LOG2    = 2,
  parameter int PRESENT_BIT = 0
) (
  input  logic [AW-1:0] req_lin,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] held_lin,
  input  logic [AW-1:0] ent_word,
  output logic [AW-1:0] dir_ent_addr,
  output logic [AW-1:0] tbl_ent_addr,
  output logic [AW-1:0] phys_addr,
  output logic          ent_present
);
  localparam int FRAME_W = AW - OFF_W;

  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] tbl_idx;
  logic [AW-1:0]    base_aligned;
  logic [AW-1:0]    ent_aligned;

  always_comb begin
    dir_idx      = req_lin[AW-1 -: IDX_W];
    tbl_idx      = held_lin[OFF_W +: IDX_W];
    base_aligned = {req_base[AW-1:OFF_W], {OFF_W{1'b0}}};
    ent_aligned  = {ent_word[AW-1:OFF_W], {OFF_W{1'b0}}};
    dir_ent_addr = base_aligned + ({{(AW-IDX_W){1'b0}}, dir_idx} << ENT_LOG2);
    tbl_ent_addr = ent_aligned  + ({{(AW-IDX_W){1'b0}}, tbl_idx} << ENT_LOG2);
    phys_addr    = ent_aligned | {{FRAME_W{1'b0}}, held_lin[OFF_W-1:0]};
    ent_present  = ent_word[PRESENT_BIT];
  end
endmodule

// File: rtl/pgwalk_ctrl.sv
// Walk sequencer: idle -> directory fetch -> table fetch -> done/fault.
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_lin,
  input  logic          mem_ack,
  input  logic [AW-1:0] dir_ent_addr,
  input  logic [AW-1:0] tbl_ent_addr,
  input  logic [AW-1:0] phys_addr,
  input  logic          ent_present,
  output logic [AW-1:0] held_lin,
  output logic          req_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          done_valid,
  output logic          done_fault,
  output logic          done_lvl,
  output logic [AW-1:0] done_paddr
);
  walk_state_t state_q;
  logic [AW-1:0] lin_q;
  logic [AW-1:0] rd_addr_q;
  logic [AW-1:0] paddr_q;
  logic          fault_q;
  walk_level_t   lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      lin_q     <= '0;
      rd_addr_q <= '0;
      paddr_q   <= '0;
      fault_q   <= 1'b0;
      lvl_q     <= LVL_DIR;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            lin_q     <= req_lin;
            rd_addr_q <= dir_ent_addr;
            state_q   <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (mem_ack) begin
            if (!ent_present) begin
              fault_q <= 1'b1;
              lvl_q   <= LVL_DIR;
              paddr_q <= '0;
              state_q <= ST_FAULT;
            end else begin
              rd_addr_q <= tbl_ent_addr;
              state_q   <= ST_TBL;
            end
          end
        end
        ST_TBL: begin
          if (mem_ack) begin
            if (!ent_present) begin
              fault_q <= 1'b1;
              lvl_q   <= LVL_TBL;
              paddr_q <= '0;
              state_q <= ST_FAULT;
            end else begin
              fault_q <= 1'b0;
              lvl_q   <= LVL_DIR;
              paddr_q <= phys_addr;
              state_q <= ST_DONE;
            end
          end
        end
        ST_DONE, ST_FAULT: state_q <= ST_IDLE;
        default:           state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    held_lin   = lin_q;
    req_ready  = (state_q == ST_IDLE);
    mem_req    = (state_q == ST_DIR) || (state_q == ST_TBL);
    mem_addr   = rd_addr_q;
    done_valid = (state_q == ST_DONE) || (state_q == ST_FAULT);
    done_fault = fault_q;
    done_lvl   = lvl_q;
    done_paddr = paddr_q;
  end
endmodule

// File: rtl/pgwalk.sv
module pgwalk #(
  parameter int AW          = 32,
  parameter int OFF_W       = 12,
  parameter int IDX_W       = 10,
  parameter int ENT_LOG2    = 2,
  parameter int PRESENT_BIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dir_base_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  output logic          mem_rd_req_o,
  output logic [AW-1:0] mem_rd_addr_o,
  input  logic          mem_rd_ack_i,
  input  logic [AW-1:0] mem_rd_data_i,
  output logic          done_valid_o,
  output logic          done_fault_o,
  output logic          done_lvl_o,
  output logic [AW-1:0] done_paddr_o
);
  logic [AW-1:0] dir_ent_addr;
  logic [AW-1:0] tbl_ent_addr;
  logic [AW-1:0] phys_addr;
  logic [AW-1:0] held_lin;
  logic          ent_present;

  pgwalk_addr #(
    .AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .ENT_LOG2(ENT_LOG2), .PRESENT_BIT(PRESENT_BIT)
  ) u_addr (
    .req_lin      (req_addr_i),
    .req_base     (dir_base_i),
    .held_lin     (held_lin),
    .ent_word     (mem_rd_data_i),
    .dir_ent_addr (dir_ent_addr),
    .tbl_ent_addr (tbl_ent_addr),
    .phys_addr    (phys_addr),
    .ent_present  (ent_present)
  );

  pgwalk_ctrl #(.AW(AW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid_i),
    .req_lin      (req_addr_i),
    .mem_ack      (mem_rd_ack_i),
    .dir_ent_addr (dir_ent_addr),
    .tbl_ent_addr (tbl_ent_addr),
    .phys_addr    (phys_addr),
    .ent_present  (ent_present),
    .held_lin     (held_lin),
    .req_ready    (req_ready_o),
    .mem_req      (mem_rd_req_o),
    .mem_addr     (mem_rd_addr_o),
    .done_valid   (done_valid_o),
    .done_fault   (done_fault_o),
    .done_lvl     (done_lvl_o),
    .done_paddr   (done_paddr_o)
  );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int AW       = 32,
  parameter int OFF_W    = 12,
  parameter int IDX_W    = 10,
  parameter int ENT_LOG2 = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] dir_base_i,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [AW-1:0] req_addr_i,
  input logic          mem_rd_req_o,
  input logic [AW-1:0] mem_rd_addr_o,
  input logic          mem_rd_ack_i,
  input logic          done_valid_o,
  input logic          done_fault_o,
  input logic [AW-1:0] done_paddr_o
);
  logic          fire;
  logic [AW-1:0] exp_first;
  logic [AW-1:0] cap_lin;

  assign fire      = req_valid_i && req_ready_o;
  assign exp_first = {dir_base_i[AW-1:OFF_W], {OFF_W{1'b0}}}
                   + ({{(AW-IDX_W){1'b0}}, req_addr_i[AW-1 -: IDX_W]} << ENT_LOG2);

  always_ff @(posedge clk) begin
    if (rst)       cap_lin <= '0;
    else if (fire) cap_lin <= req_addr_i;
  end

  assert_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> req_ready_o && !mem_rd_req_o && !done_valid_o);

  assert_first_read_R2: assert property (@(posedge clk) disable iff (rst)
    fire |=> mem_rd_req_o && (mem_rd_addr_o == $past(exp_first)));

  assert_offset_R4: assert property (@(posedge clk) disable iff (rst)
    done_valid_o && !done_fault_o |-> done_paddr_o[OFF_W-1:0] == cap_lin[OFF_W-1:0]);

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (rst)
    done_valid_o && done_fault_o |-> done_paddr_o == '0);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req_o && !mem_rd_ack_i |=> mem_rd_req_o && $stable(mem_rd_addr_o));

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
    req_ready_o |-> !mem_rd_req_o && !done_valid_o);

  assert_busy_after_fire_R8: assert property (@(posedge clk) disable iff (rst)
    fire |=> !req_ready_o);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done_valid_o |=> !done_valid_o && req_ready_o);
endmodule

bind pgwalk pgwalk_chk #(
  .AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .dir_base_i    (dir_base_i),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_addr_i    (req_addr_i),
  .mem_rd_req_o  (mem_rd_req_o),
  .mem_rd_addr_o (mem_rd_addr_o),
  .mem_rd_ack_i  (mem_rd_ack_i),
  .done_valid_o  (done_valid_o),
  .done_fault_o  (done_fault_o),
  .done_paddr_o  (done_paddr_o)
);

// File: tb/pgwalk_bench.sv
`timescale 1ns/1ps
module pgwalk_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dir_base_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic        mem_rd_req_o;
  logic [31:0] mem_rd_addr_o;
  logic        mem_rd_ack_i = 1'b0;
  logic [31:0] mem_rd_data_i = '0;
  logic        done_valid_o;
  logic        done_fault_o;
  logic        done_lvl_o;
  logic [31:0] done_paddr_o;

  int errors = 0;
  int checks = 0;

  logic [31:0] np_dir = 32'h3;  // unaligned: never matches a read
  logic [31:0] np_tbl = 32'h3;
  bit          fast_ack = 1'b0;
  int          rd_cnt = 0;
  logic [31:0] rd_log [0:3];
  int          hold_err = 0;
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;

  always #5 clk = ~clk;

  pgwalk u_pgwalk (
    .clk(clk), .rst(rst), .dir_base_i(dir_base_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .mem_rd_req_o(mem_rd_req_o), .mem_rd_addr_o(mem_rd_addr_o),
    .mem_rd_ack_i(mem_rd_ack_i), .mem_rd_data_i(mem_rd_data_i),
    .done_valid_o(done_valid_o), .done_fault_o(done_fault_o),
    .done_lvl_o(done_lvl_o), .done_paddr_o(done_paddr_o)
  );

  // Memory contents are a hash of the address; flags are random.
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] h;
    logic        pres;
    h = (a ^ (a >> 15) ^ 32'h5bd1e995) * 32'h9E3779B1;
    h = h ^ (h >> 11);
    pres = (h[7:2] != 6'd0) && (a != np_dir) && (a != np_tbl);
    return {h[31:12], h[11:1], pres};
  endfunction

  task automatic model(input logic [31:0] la, input logic [31:0] base,
                       output logic flt, output logic lvl, output logic [31:0] pa,
                       output logic [31:0] de_a, output logic [31:0] te_a, output int nrd);
    logic [31:0] de, te;
    de_a = {base[31:12], 12'h0} + {20'h0, la[31:22], 2'b00};
    de   = mem_word(de_a);
    te_a = {de[31:12], 12'h0} + {20'h0, la[21:12], 2'b00};
    te   = mem_word(te_a);
    if (!de[0]) begin flt = 1; lvl = 0; pa = 0; nrd = 1; end
    else if (!te[0]) begin flt = 1; lvl = 1; pa = 0; nrd = 2; end
    else begin flt = 0; lvl = 0; pa = {te[31:12], la[11:0]}; nrd = 2; end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory responder: random acknowledge latency, records read addresses.
  always @(negedge clk) begin
    if (!rst && prev_pend && mem_rd_addr_o != prev_addr) hold_err++;
    if (!rst && mem_rd_req_o && (fast_ack || $urandom_range(0, 2) == 0)) begin
      mem_rd_ack_i  = 1'b1;
      mem_rd_data_i = mem_word(mem_rd_addr_o);
      if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr_o;
      rd_cnt++;
      prev_pend = 1'b0;
    end else begin
      mem_rd_ack_i  = 1'b0;
      mem_rd_data_i = $urandom;
      prev_pend = !rst && mem_rd_req_o;
    end
    prev_addr = mem_rd_addr_o;
  end

  task automatic walk(input logic [31:0] la, input logic [31:0] base,
                      input bit swap, input logic [31:0] base2);
    logic flt, lvl; logic [31:0] pa, de_a, te_a; int nrd; int n; bit busy_bad;
    model(la, base, flt, lvl, pa, de_a, te_a, nrd);
    @(negedge clk);
    rd_cnt = 0;
    req_addr_i = la; dir_base_i = base; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    req_addr_i  = $urandom;
    if (swap) dir_base_i = base2;
    n = 0; busy_bad = 0;
    while (!done_valid_o && n < 1000) begin
      if (req_ready_o) busy_bad = 1;
      @(negedge clk);
      n++;
    end
    chk(n < 1000, "R10 result pulse arrives", n, 0);
    chk(!busy_bad, "R8 ready low while walking", busy_bad, 0);
    chk(rd_cnt == nrd, flt && !lvl ? "R5 read count" : "R6 read count", rd_cnt, nrd);
    chk(rd_log[0] == de_a, swap ? "R9 first read uses captured base" : "R2 directory entry address",
        rd_log[0], de_a);
    if (nrd == 2 && rd_cnt >= 2) chk(rd_log[1] == te_a, "R3 table entry address", rd_log[1], te_a);
    chk(done_fault_o == flt, flt ? (lvl ? "R6 fault flag" : "R5 fault flag") : "R4 no fault",
        done_fault_o, flt);
    if (flt) chk(done_lvl_o == lvl, lvl ? "R6 fault level" : "R5 fault level", done_lvl_o, lvl);
    chk(done_paddr_o == pa, flt ? "R5 R6 paddr zero on fault" : "R4 physical address",
        done_paddr_o, pa);
    @(negedge clk);
    chk(!done_valid_o && req_ready_o, "R10 single pulse then ready",
        {done_valid_o, req_ready_o}, 2'b01);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic flt, lvl; logic [31:0] pa, de_a, te_a; int nrd;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(req_ready_o && !mem_rd_req_o && !done_valid_o, "R1 reset state",
        {req_ready_o, mem_rd_req_o, done_valid_o}, 3'b100);

    // Directed: extremes of address and base, nonzero base flag bits.
    fast_ack = 1;
    walk(32'h0000_0000, 32'h0000_0000, 0, 0);
    walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    fast_ack = 0;
    walk(32'h1234_5ABC, 32'h0040_0FFF, 0, 0);

    // Directed: missing directory entry (R5).
    model(32'h8765_4321, 32'h0010_0000, flt, lvl, pa, de_a, te_a, nrd);
    np_dir = de_a;
    walk(32'h8765_4321, 32'h0010_0000, 0, 0);
    np_dir = 32'h3;

    // Directed: missing table entry (R6).
    model(32'h0BAD_F00D, 32'h0020_0123, flt, lvl, pa, de_a, te_a, nrd);
    np_tbl = te_a;
    walk(32'h0BAD_F00D, 32'h0020_0123, 0, 0);
    np_tbl = 32'h3;

    // Directed: base swapped mid-walk (R9), then the new base applies.
    walk(32'h4444_5555, 32'h0A00_0000, 1, 32'h0B00_0000);
    walk(32'h4444_5555, 32'h0B00_0000, 0, 0);

    // Random walks.
    for (int i = 0; i < 300; i++) begin
      fast_ack = ($urandom_range(0, 3) == 0);
      walk($urandom, $urandom, ($urandom_range(0, 7) == 0), $urandom);
    end

    chk(hold_err == 0, "R7 read held until acknowledge", hold_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule